// File: doc/BRIEF.md
# Double-Precision Funnel Shifter

This combinational block computes the result of a double-precision shift. A destination value is shifted left or right by a count, and the bit positions it vacates are filled from a second register value instead of with zeros. The block handles 16-, 32- and 64-bit operand sizes. The 8-bit count can come from an immediate byte or from the low byte of a count register; the block masks it the same way in both cases.

The block returns four things: the result truncated to the operand size, a flag that marks the result as undefined, the carry flag, and an indication of whether the flags were updated. The surrounding execution unit supplies the operands and the incoming carry. It also decides what to write back when the result is undefined.

Top module: `dp_funnel_shift`

## Requirements
- R1: `size_i` selects the operand width: 0 is 16 bits, 1 is 32 bits, 2 is 64 bits, and 3 behaves exactly like 2. The bits of `result_o` above the selected width are always zero.
- R2: The effective count is `count_i[5:0]` when the width is 64. At 16 or 32 bits it is `count_i[4:0]`. The other count bits have no effect.
- R3: When `dir_left_i` is 1 and the effective count n is in 1..W, `result_o` is the upper W bits of the 2W-bit value {dst, src} shifted left by n. Here dst and src are the low W bits of `dst_i` and `src_i`.
- R4: When `dir_left_i` is 0 and n is in 1..W, `result_o` is the lower W bits of {src, dst} shifted right by n.
- R5: When n is in 1..W, `cf_o` is the last destination bit shifted out. For a left shift that is dst bit W-n; for a right shift it is dst bit n-1.
- R6: When n is 0, `result_o` equals dst truncated to W bits, `cf_o` equals `cf_i`, `flags_valid_o` is 0 and `undef_o` is 0.
- R7: When n is greater than W, `undef_o` is 1, `result_o` is 0, `cf_o` equals `cf_i` and `flags_valid_o` is 0. This can only happen at 16 bits.
- R8: `flags_valid_o` is 1 exactly when n is in 1..W.
- R9: A count equal to the width is a defined case, and the result equals src in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dst_i | input | 64 | Destination operand, the value being shifted |
| src_i | input | 64 | Fill operand, supplies the bits shifted in |
| count_i | input | 8 | Raw shift count, from an immediate or from the count register's low byte |
| size_i | input | 2 | Operand width select |
| dir_left_i | input | 1 | 1 for a left shift, 0 for a right shift |
| cf_i | input | 1 | Incoming carry flag |
| result_o | output | 64 | Shifted result, zero above the operand width |
| undef_o | output | 1 | Result is architecturally undefined |
| cf_o | output | 1 | Outgoing carry flag |
| flags_valid_o | output | 1 | Flags were updated by this shift |

## Verification
The bench sweeps every raw count value at every size code and in both directions, using several operand patterns. Its expected values come from wide-integer arithmetic.

It covers the following corner cases:
- **Mask width swapped between sizes:** a 32-bit count of 37 is treated as 37 instead of 5.
- **Boundary of the undefined range:** at 16 bits a count of exactly 16 must return src, while 17 must raise `undef_o`. An off-by-one comparison either flags 16 or lets 17 through.
- **Zero count:** a design that updates the carry on a zero count, or passes bits above the width, fails on the patterns with all bits set.
- **Carry bit index:** picking the first bit shifted out instead of the last shows up at every count above 1.

// File: rtl/fsh_pkg.sv
package fsh_pkg;

    localparam int DATA_W  = 64;
    localparam int CNT_W   = 8;
    localparam int AMT_W   = $clog2(DATA_W);
    localparam int WIDTH_W = AMT_W + 1;
    localparam int NUM_LANES = 3;

    typedef enum logic [1:0] {
        SZ_16  = 2'd0,
        SZ_32  = 2'd1,
        SZ_64  = 2'd2,
        SZ_64X = 2'd3
    } opsize_e;

    typedef struct packed {
        logic [AMT_W-1:0] amt;
        logic             is_zero;
        logic             over;
    } cnt_info_t;

    typedef struct packed {
        logic [DATA_W-1:0] value;
        logic              carry;
    } lane_out_t;

    function automatic logic is_wide(opsize_e s);
        return (s == SZ_64) || (s == SZ_64X);
    endfunction

    function automatic int unsigned lane_of(opsize_e s);
        case (s)
            SZ_16:   return 0;
            SZ_32:   return 1;
            default: return 2;
        endcase
    endfunction

    function automatic logic [WIDTH_W-1:0] width_of(opsize_e s);
        case (s)
            SZ_16:   return WIDTH_W'(DATA_W / 4);
            SZ_32:   return WIDTH_W'(DATA_W / 2);
            default: return WIDTH_W'(DATA_W);
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] keep_mask(opsize_e s);
        case (s)
            SZ_16:   return {{(DATA_W*3/4){1'b0}}, {(DATA_W/4){1'b1}}};
            SZ_32:   return {{(DATA_W/2){1'b0}}, {(DATA_W/2){1'b1}}};
            default: return {DATA_W{1'b1}};
        endcase
    endfunction

endpackage

// File: rtl/fsh_count_unit.sv
module fsh_count_unit
    import fsh_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int AW = AMT_W
) (
    input  logic [CW-1:0] count_i,
    input  opsize_e       size_i,
    output cnt_info_t     info_o
);

    logic [AW-1:0]      amt;
    logic [WIDTH_W-1:0] width;

    always_comb begin
        if (is_wide(size_i)) begin
            amt = count_i[AW-1:0];
        end else begin
            amt = {1'b0, count_i[AW-2:0]};
        end
        width          = width_of(size_i);
        info_o.amt     = amt;
        info_o.is_zero = (amt == '0);
        info_o.over    = ({1'b0, amt} > width);
    end

    always_comb begin
        if (!is_wide(size_i)) begin
            a_r2_narrow_mask: assert (info_o.amt[AW-1] == 1'b0);
        end
        if (info_o.over) begin
            a_r7_over_narrow: assert (size_i == SZ_16);
        end
    end

endmodule

// File: rtl/fsh_lane.sv
module fsh_lane
    import fsh_pkg::*;
#(
    parameter int W  = 16,
    parameter int AW = AMT_W
) (
    input  logic [W-1:0]  dst_i,
    input  logic [W-1:0]  src_i,
    input  logic [AW-1:0] amt_i,
    input  logic          left_i,
    output logic [W-1:0]  res_o,
    output logic          carry_o
);

    localparam int CAT_W = 2 * W;

    logic [CAT_W-1:0] cat_l;
    logic [CAT_W-1:0] cat_r;
    logic [CAT_W-1:0] shl_n;
    logic [CAT_W-1:0] shl_p;
    logic [CAT_W-1:0] shr_n;
    logic [CAT_W-1:0] shr_p;
    logic [AW-1:0]    amt_m1;

    always_comb begin
        cat_l  = {dst_i, src_i};
        cat_r  = {src_i, dst_i};
        amt_m1 = amt_i - AW'(1);
        shl_n  = cat_l << amt_i;
        shl_p  = cat_l << amt_m1;
        shr_n  = cat_r >> amt_i;
        shr_p  = cat_r >> amt_m1;
        if (left_i) begin
            res_o   = shl_n[CAT_W-1:W];
            carry_o = shl_p[CAT_W-1];
        end else begin
            res_o   = shr_n[W-1:0];
            carry_o = shr_p[0];
        end
    end

    always_comb begin
        if (32'(amt_i) == W) begin
            a_r9_full_count: assert (res_o == src_i);
        end
    end

endmodule

// File: rtl/fsh_select.sv
module fsh_select
    import fsh_pkg::*;
#(
    parameter int N = NUM_LANES
) (
    input  lane_out_t lane_i [N],
    input  opsize_e   size_i,
    output lane_out_t pick_o
);

    always_comb begin
        pick_o = lane_i[N-1];
        for (int k = 0; k < N; k++) begin
            if (lane_of(size_i) == k) begin
                pick_o = lane_i[k];
            end
        end
    end

endmodule

// File: rtl/dp_funnel_shift.sv
module dp_funnel_shift
    import fsh_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = CNT_W
) (
    input  logic [DW-1:0] dst_i,
    input  logic [DW-1:0] src_i,
    input  logic [CW-1:0] count_i,
    input  logic [1:0]    size_i,
    input  logic          dir_left_i,
    input  logic          cf_i,
    output logic [DW-1:0] result_o,
    output logic          undef_o,
    output logic          cf_o,
    output logic          flags_valid_o
);

    opsize_e   size;
    cnt_info_t info;
    lane_out_t lanes [NUM_LANES];
    lane_out_t pick;

    assign size = opsize_e'(size_i);

    fsh_count_unit #(.CW(CW), .AW(AMT_W)) u_cnt (
        .count_i (count_i),
        .size_i  (size),
        .info_o  (info)
    );

    for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
        localparam int LW = DW >> (NUM_LANES - 1 - k);
        logic [LW-1:0] res;
        logic          carry;

        fsh_lane #(.W(LW), .AW(AMT_W)) u_lane (
            .dst_i   (dst_i[LW-1:0]),
            .src_i   (src_i[LW-1:0]),
            .amt_i   (info.amt),
            .left_i  (dir_left_i),
            .res_o   (res),
            .carry_o (carry)
        );

        always_comb begin
            lanes[k].value = DW'(res);
            lanes[k].carry = carry;
        end
    end

    fsh_select #(.N(NUM_LANES)) u_sel (
        .lane_i (lanes),
        .size_i (size),
        .pick_o (pick)
    );

    always_comb begin
        if (info.is_zero) begin
            result_o      = dst_i & keep_mask(size);
            cf_o          = cf_i;
            flags_valid_o = 1'b0;
            undef_o       = 1'b0;
        end else if (info.over) begin
            result_o      = '0;
            cf_o          = cf_i;
            flags_valid_o = 1'b0;
            undef_o       = 1'b1;
        end else begin
            result_o      = pick.value;
            cf_o          = pick.carry;
            flags_valid_o = 1'b1;
            undef_o       = 1'b0;
        end
    end

    always_comb begin
        a_r8_valid_excl: assert (!(flags_valid_o && undef_o));
        a_r1_upper_zero: assert ((result_o & ~keep_mask(size)) == '0);
        if (!flags_valid_o) begin
            a_r6_carry_held: assert (cf_o == cf_i);
        end
        if (undef_o) begin
            a_r7_zero_result: assert (result_o == '0);
        end
    end

endmodule

// File: tb/sim_dp_funnel_shift.sv
module sim_dp_funnel_shift;

    logic        clk = 1'b0;
    logic [63:0] dst, src;
    logic [7:0]  cnt;
    logic [1:0]  sz;
    logic        dl, ci;
    logic [63:0] res;
    logic        und, co, fv;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    dp_funnel_shift u0 (
        .dst_i(dst), .src_i(src), .count_i(cnt), .size_i(sz),
        .dir_left_i(dl), .cf_i(ci), .result_o(res), .undef_o(und),
        .cf_o(co), .flags_valid_o(fv)
    );

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h (size=%0d cnt=%0d left=%0b)",
                     tag, got, exp, sz, cnt, dl);
        end
    endtask

    task automatic run(input logic [63:0] d, input logic [63:0] s, input logic [7:0] c,
                       input logic [1:0] z, input logic l, input logic cin,
                       input string rtag);
        int           w;
        int           m;
        logic [63:0]  msk, dw, sw, er;
        logic [127:0] t;
        logic         ec, ev, eu;
        string        cat;
        @(negedge clk);
        dst = d; src = s; cnt = c; sz = z; dl = l; ci = cin;
        #2;
        w   = (z == 2'd0) ? 16 : (z == 2'd1) ? 32 : 64;
        msk = (w == 64) ? {64{1'b1}} : ((64'd1 << w) - 64'd1);
        m   = z[1] ? int'(c % 64) : int'(c % 32);
        dw  = d & msk;
        sw  = s & msk;
        if (m == 0) begin
            er = dw; ec = cin; ev = 0; eu = 0; cat = "R6";
        end else if (m > w) begin
            er = 0; ec = cin; ev = 0; eu = 1; cat = "R7";
        end else if (l) begin
            t  = (({64'd0, dw} << w) | {64'd0, sw}) << m;
            t  = t >> w;
            er = t[63:0] & msk;
            ec = dw[w-m]; ev = 1; eu = 0; cat = "R3";
        end else begin
            t  = (({64'd0, sw} << w) | {64'd0, dw}) >> m;
            er = t[63:0] & msk;
            ec = dw[m-1]; ev = 1; eu = 0; cat = "R4";
        end
        chk((rtag != "") ? rtag : cat, res, er);
        chk((ev) ? "R5" : cat, {63'd0, co}, {63'd0, ec});
        chk("R8", {63'd0, fv}, {63'd0, ev});
        chk("R7", {63'd0, und}, {63'd0, eu});
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [63:0] pd [4];
        logic [63:0] ps [4];
        pd[0] = 64'h0123_4567_89AB_CDEF; ps[0] = 64'hFEDC_BA98_7654_3210;
        pd[1] = 64'hFFFF_FFFF_FFFF_FFFF; ps[1] = 64'h0000_0000_0000_0000;
        pd[2] = 64'h0000_0000_0000_0000; ps[2] = 64'hFFFF_FFFF_FFFF_FFFF;
        pd[3] = 64'h8000_0001_8001_8001; ps[3] = 64'h5A5A_A5A5_3C3C_C3C3;
        dst = '0; src = '0; cnt = '0; sz = '0; dl = 0; ci = 0;

        // reset-like idle state: zero count, 16-bit, all-zero operands (R6)
        run(64'd0, 64'd0, 8'd0, 2'd0, 1'b0, 1'b0, "R6");

        // R9: count equal to the width returns src in both directions
        run(64'h1234, 64'hABCD, 8'd16, 2'd0, 1'b1, 1'b0, "R9");
        run(64'h1234, 64'hABCD, 8'd16, 2'd0, 1'b0, 1'b1, "R9");
        // R7 boundary: 17 at 16 bits is undefined
        run(64'h1234, 64'hABCD, 8'd17, 2'd0, 1'b1, 1'b1, "R7");
        // R2: high count bits ignored
        run(pd[0], ps[0], 8'd69,  2'd2, 1'b1, 1'b0, "R2");
        run(pd[0], ps[0], 8'd37,  2'd1, 1'b0, 1'b0, "R2");
        run(pd[3], ps[3], 8'hE3,  2'd0, 1'b1, 1'b1, "R2");
        // R1: size code 3 acts as 64 bits, upper bits of narrow sizes zero
        run(pd[3], ps[3], 8'd13,  2'd3, 1'b0, 1'b0, "R1");
        run(pd[1], ps[1], 8'd0,   2'd1, 1'b0, 1'b0, "R1");

        for (int p = 0; p < 4; p++) begin
            for (int z = 0; z < 4; z++) begin
                for (int l = 0; l < 2; l++) begin
                    for (int c = 0; c < 256; c++) begin
                        run(pd[p], ps[p], 8'(c), 2'(z), l[0], c[0] ^ p[0],
                            (z == 3) ? "R1" : "");
                    end
                end
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule